// File: doc/BRIEF.md
# Page class key access checker

This block guards memory accesses of a 64-bit hashed page table MMU by page class. Each page table entry carries a 5-bit class number split across two fields of its second doubleword. The block rebuilds that number, looks up two permission bits for the class in a 64-bit access mask register, and raises a protection fault when a read or a write is forbidden for that class. The fault path is purely combinational, so the MMU can use it in the same cycle that it has the entry.

The block also holds the access mask and a second, privileged user-enable mask, with one register port that reads and writes both. Supervisor software may load either register in full. User software may write the access mask, but only the bit positions that the user-enable mask permits change. A user attempt to write the user-enable mask is refused and flagged as a privilege exception.

Top module: `pkey_guard`

## Requirements
- R1: The class key is {entry[63:62], entry[11:9]}: entry bits 63:62 become key bits 4:3 and entry bits 11:9 become key bits 2:0; no other entry bit affects the result.
- R2: For a valid read of class k, `prot_fault` is 1 exactly when access mask bit 2k+1 (read-forbid) is 1.
- R3: For a valid write of class k, `prot_fault` is 1 exactly when access mask bit 2k (write-forbid) is 1.
- R4: When `acc_valid` is 0, `prot_fault` is 0 whatever the mask holds.
- R5: After reset both registers read as zero, so no access faults.
- R6: A supervisor write (`reg_user` = 0) loads the full 64-bit `reg_wdata` into the selected register (`reg_sel` 0 = access mask, 1 = user-enable mask).
- R7: A user write to the access mask sets each bit to `reg_wdata` where the user-enable mask bit is 1 and keeps the old bit where it is 0.
- R8: A user write to the user-enable mask leaves it unchanged and drives `priv_exc` to 1 in that cycle.
- R9: `reg_rdata` shows the register picked by `reg_sel` in the same cycle, in either privilege mode.
- R10: A register write takes effect at the next rising clock edge; a fault check in the write cycle uses the old mask.
- R11: `priv_exc` is 0 whenever there is no user-mode write to the user-enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pte_word | input | 64 | Second doubleword of the page table entry |
| acc_valid | input | 1 | An access is being checked this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| prot_fault | output | 1 | Access forbidden by its class permissions |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = access mask, 1 = user-enable mask |
| reg_user | input | 1 | 1 = requester runs in user mode |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_sel` |
| priv_exc | output | 1 | User-mode write to the privileged mask refused |

## Verification
The hardest case to reach is a user write to the access mask where the user-enable mask allows only some bits and the written data differs from the old value both inside and outside the allowed set. The bench first loads both registers from supervisor mode with independent patterns, then issues user writes with fresh data. It reads back the merge and sweeps all 32 classes for reads and writes. The same-cycle rule is reached by holding a checked access on the ports while a write to the mask is pending.

// File: rtl/pkey_pkg.sv
`timescale 1ns/1ps
package pkey_pkg;
    localparam int unsigned REG_W = 64;

    typedef enum logic {
        SEL_AMASK = 1'b0,
        SEL_UMASK = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] amask;
        logic [REG_W-1:0] umask;
    } mask_state_t;
endpackage

// File: rtl/pkey_key_extract.sv
`timescale 1ns/1ps
module pkey_key_extract #(
    parameter int unsigned ENTRY_W = 64,
    parameter int unsigned LO_POS  = 9,
    parameter int unsigned LO_W    = 3,
    parameter int unsigned HI_POS  = 62,
    parameter int unsigned HI_W    = 2,
    localparam int unsigned KEY_W  = LO_W + HI_W
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic [KEY_W-1:0]   key
);
    logic [LO_W-1:0] lo_part;
    logic [HI_W-1:0] hi_part;

    always_comb begin
        lo_part = entry[LO_POS +: LO_W];
        hi_part = entry[HI_POS +: HI_W];
        key     = {hi_part, lo_part};
    end
endmodule

// File: rtl/pkey_perm_lookup.sv
`timescale 1ns/1ps
module pkey_perm_lookup #(
    parameter int unsigned KEY_W   = 5,
    localparam int unsigned CLASS_N = 1 << KEY_W,
    localparam int unsigned MASK_W  = 2 * CLASS_N
) (
    input  logic [MASK_W-1:0] amask,
    input  logic [KEY_W-1:0]  key,
    input  logic              valid,
    input  logic              is_write,
    output logic              fault
);
    logic [CLASS_N-1:0] wr_forbid;
    logic [CLASS_N-1:0] rd_forbid;

    for (genvar k = 0; k < CLASS_N; k++) begin : g_class
        assign wr_forbid[k] = amask[2*k];
        assign rd_forbid[k] = amask[2*k+1];
    end

    always_comb begin
        fault = 1'b0;
        if (valid) begin
            fault = is_write ? wr_forbid[key] : rd_forbid[key];
        end
    end
endmodule

// File: rtl/pkey_mask_regs.sv
`timescale 1ns/1ps
module pkey_mask_regs
    import pkey_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic             user,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] amask_q,
    output logic [REG_W-1:0] umask_q,
    output logic             priv_exc
);
    mask_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        priv_exc = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_AMASK: begin
                    if (user) begin
                        st_d.amask = (st_q.amask & ~st_q.umask) | (wdata & st_q.umask);
                    end else begin
                        st_d.amask = wdata;
                    end
                end
                SEL_UMASK: begin
                    if (user) begin
                        priv_exc = 1'b1;
                    end else begin
                        st_d.umask = wdata;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign amask_q = st_q.amask;
    assign umask_q = st_q.umask;

    // R7: user writes never touch bits the user-enable mask keeps closed
    assert_user_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && user && sel == SEL_AMASK) |=>
        (((amask_q ^ $past(amask_q)) & ~$past(umask_q)) == '0));

    // R8: the privileged mask survives a user write
    assert_umask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && user && sel == SEL_UMASK) |=> $stable(umask_q));

    // R6: supervisor write loads the whole word
    assert_sup_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !user && sel == SEL_AMASK) |=> (amask_q == $past(wdata)));

    // R10: without a write strobe neither register moves
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(amask_q) && $stable(umask_q)));

    // R11: exception flag only on a write strobe
    assert_exc_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        priv_exc |-> (wr_en && user));
endmodule

// File: rtl/pkey_guard.sv
`timescale 1ns/1ps
module pkey_guard
    import pkey_pkg::*;
#(
    parameter int unsigned KEY_LO_POS = 9,
    parameter int unsigned KEY_LO_W   = 3,
    parameter int unsigned KEY_HI_POS = 62,
    parameter int unsigned KEY_HI_W   = 2,
    localparam int unsigned KEY_W     = KEY_LO_W + KEY_HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] pte_word,
    input  logic             acc_valid,
    input  logic             acc_write,
    output logic             prot_fault,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic             reg_user,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             priv_exc
);
    logic [KEY_W-1:0] class_key;
    logic [REG_W-1:0] amask_q;
    logic [REG_W-1:0] umask_q;
    reg_sel_e         sel_e;

    assign sel_e = reg_sel_e'(reg_sel);

    pkey_key_extract #(
        .ENTRY_W (REG_W),
        .LO_POS  (KEY_LO_POS),
        .LO_W    (KEY_LO_W),
        .HI_POS  (KEY_HI_POS),
        .HI_W    (KEY_HI_W)
    ) i_extract (
        .entry (pte_word),
        .key   (class_key)
    );

    pkey_perm_lookup #(
        .KEY_W (KEY_W)
    ) i_lookup (
        .amask    (amask_q),
        .key      (class_key),
        .valid    (acc_valid),
        .is_write (acc_write),
        .fault    (prot_fault)
    );

    pkey_mask_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (sel_e),
        .user     (reg_user),
        .wdata    (reg_wdata),
        .amask_q  (amask_q),
        .umask_q  (umask_q),
        .priv_exc (priv_exc)
    );

    always_comb begin
        reg_rdata = (sel_e == SEL_UMASK) ? umask_q : amask_q;
    end

    // R4: an idle access port never reports a fault
    assert_idle_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !prot_fault);

    // R5: a cleared mask cannot forbid anything
    assert_clear_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (amask_q == '0) |-> !prot_fault);
endmodule

// File: tb/test_pkey_guard.sv
`timescale 1ns/1ps
module test_pkey_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pte_word = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        prot_fault;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_user = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        priv_exc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] m_amask = '0;
    logic [63:0] m_umask = '0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    pkey_guard i_pkey_guard (
        .clk(clk), .rst_n(rst_n), .pte_word(pte_word), .acc_valid(acc_valid),
        .acc_write(acc_write), .prot_fault(prot_fault), .reg_wr_en(reg_wr_en),
        .reg_sel(reg_sel), .reg_user(reg_user), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .priv_exc(priv_exc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic logic [63:0] make_pte(input logic [4:0] key, input logic [63:0] fill);
        logic [63:0] p;
        p = fill;
        p[63:62] = key[4:3];
        p[11:9]  = key[2:0];
        return p;
    endfunction

    task automatic reg_write(input logic sel, input logic user, input logic [63:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_user = user; reg_wdata = data;
        #1;
        chk((sel && user) ? "R8" : "R11", {63'd0, priv_exc}, {63'd0, sel && user});
        @(posedge clk);
        if (!sel && !user) m_amask = data;
        if (!sel && user)  m_amask = (m_amask & ~m_umask) | (data & m_umask);
        if (sel && !user)  m_umask = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic readback(input string req);
        @(negedge clk);
        reg_sel = 1'b0; reg_user = 1'b1; #1;
        chk(req, reg_rdata, m_amask);
        reg_sel = 1'b1; reg_user = 1'b0; #1;
        chk(req, reg_rdata, m_umask);
    endtask

    task automatic sweep();
        for (int k = 0; k < 32; k++) begin
            for (int w = 0; w < 2; w++) begin
                @(negedge clk);
                pte_word = make_pte(5'(k), next_rand());
                acc_write = w[0]; acc_valid = 1'b1; #1;
                // R1 key mapping exercised through the fault
                if (w == 0) chk("R2", {63'd0, prot_fault}, {63'd0, m_amask[2*k+1]});
                else        chk("R3", {63'd0, prot_fault}, {63'd0, m_amask[2*k]});
                acc_valid = 1'b0; #1;
                chk("R4", {63'd0, prot_fault}, 64'd0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        readback("R5");
        sweep();

        // R1: only one class forbidden, other entry bits flooded
        reg_write(1'b0, 1'b0, 64'h1 << (2*19 + 1));
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            pte_word = make_pte(5'(k), ~64'd0); acc_write = 1'b0; acc_valid = 1'b1; #1;
            chk("R1", {63'd0, prot_fault}, {63'd0, k == 19});
        end
        acc_valid = 1'b0;

        // R6 and R2, R3: supervisor patterns
        reg_write(1'b0, 1'b0, ~64'd0);        readback("R6"); sweep();
        reg_write(1'b0, 1'b0, 64'h5555_5555_5555_5555); readback("R6"); sweep();
        reg_write(1'b0, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA); readback("R6"); sweep();
        for (int i = 0; i < 3; i++) begin
            reg_write(1'b0, 1'b0, next_rand()); readback("R6"); sweep();
        end

        // R7: user merges through independent enable patterns
        for (int i = 0; i < 6; i++) begin
            reg_write(1'b1, 1'b0, next_rand());
            reg_write(1'b0, 1'b0, next_rand());
            reg_write(1'b0, 1'b1, next_rand());
            readback("R7");
            if (i < 2) sweep();
        end

        // R8: user cannot alter the enable mask
        for (int i = 0; i < 3; i++) begin
            reg_write(1'b1, 1'b1, next_rand());
            readback("R8");
        end

        // R9: read in user mode of both registers
        @(negedge clk);
        reg_user = 1'b1; reg_sel = 1'b1; #1;
        chk("R9", reg_rdata, m_umask);
        reg_sel = 1'b0; #1;
        chk("R9", reg_rdata, m_amask);

        // R10: same-cycle check sees the old mask
        reg_write(1'b0, 1'b0, 64'd0);
        @(negedge clk);
        pte_word = make_pte(5'd7, 64'd0); acc_valid = 1'b1; acc_write = 1'b1;
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_user = 1'b0; reg_wdata = ~64'd0; #1;
        chk("R10", {63'd0, prot_fault}, 64'd0);
        chk("R11", {63'd0, priv_exc}, 64'd0);
        @(posedge clk); m_amask = ~64'd0;
        @(negedge clk);
        reg_wr_en = 1'b0; #1;
        chk("R10", {63'd0, prot_fault}, 64'd1);
        acc_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule